// File: doc/BRIEF.md
# Three-Axis Parallel Integer Dot-Product Array

This block is the arithmetic core of a layer-at-a-time neural network engine. In every cycle it takes one tile of 8-bit signed activations and one tile of 8-bit signed weights. It computes many dot products from them at once, spread over three axes:

- **Filters (PF):** one processing unit per output filter.
- **Output positions (PV):** inside each unit, one multiply-add lane per output position.
- **Input channels (PC):** inside each lane, a row of multipliers reduced by an adder tree.

All lanes of a unit see the same weight row. All units see the same activation tile.

A dot product longer than one tile is built by streaming tiles in order. The first tile of a job restarts each lane's accumulator. The last tile marks the job complete, and a one-cycle valid flag follows once the result has passed through the pipeline. The same array serves fully connected and convolution layers, because the scheduler upstream turns any kernel size into a sequence of channel tiles.

The pipeline is fixed: one product register, one register per adder-tree level and one accumulator register. The latency from a tile's input to its effect on the outputs is therefore `$clog2(PC) + 2` cycles. A new tile can be accepted every cycle.

Top module: `mac_grid`

## Requirements
- R1: After reset, and until the first accepted tile has reached the accumulator, every lane of `sum_o` reads zero and `sum_valid_o` is low.
- R2: The lane for filter f and position v computes the sum over c of act(v,c)·wgt(f,c). Bit fields are located as follows:
  - act(v,c) sits at `act_i[(v*PC+c)*8 +: 8]`.
  - wgt(f,c) sits at `wgt_i[(f*PC+c)*8 +: 8]`.
  - The lane's result sits at `sum_o[(f*PV+v)*32 +: 32]`.
- R3: Operands and results are two's complement. Each product is a full signed 8x8 product, including -128·-128 = 16384. Sums accumulate in 32 bits, so negative and multi-tile totals beyond 16 bits come out exact.
- R4: A tile accepted with `first_i` high replaces the lane accumulators with that tile's dot products, discarding any earlier total. A tile accepted with `first_i` low adds to the running total.
- R5: When a tile is accepted with `last_i` high, `sum_valid_o` is high for exactly that one cycle, `$clog2(PC)+2` cycles later (4 cycles for PC=4), and `sum_o` then holds the finished job total.
- R6: A cycle with `in_valid_i` low changes nothing: its data and flags are ignored, and `sum_o` holds its value. Such idle cycles may also fall between the tiles of one job without changing the result.
- R7: Tiles may be accepted on consecutive cycles, including a new job's first tile right after the previous job's last tile, and each job's total appears in its own valid cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Tile on the data inputs is accepted this cycle |
| first_i | input | 1 | Accepted tile starts a new accumulation |
| last_i | input | 1 | Accepted tile ends the accumulation |
| act_i | input | PV*PC*8 | Activation tile, PV positions by PC channels |
| wgt_i | input | PF*PC*8 | Weight tile, PF filters by PC channels |
| sum_o | output | PF*PV*32 | Lane accumulators, PF filters by PV positions |
| sum_valid_o | output | 1 | One-cycle pulse: `sum_o` holds finished totals |

## Verification
The bench drives the extreme operands -128 and 127. A design that multiplied unsigned, or truncated the products, would give wrong signs or a wrong magnitude at these values. It runs long jobs whose totals pass 2^21, which exposes accumulators that are too narrow or do not sign-extend. It starts a job right after another job has finished, which catches an accumulator that keeps the old total across a first tile. It sends tiles back to back and with gaps in between, which would show a control pipeline that is out of step with the data by even one stage: valid would arrive early or late, or a gap would add garbage. Its random tiles have distinct values in every lane, so swapped filter or position indexing shows up as a wrong lane.

// File: rtl/mac_grid_pkg.sv
package mac_grid_pkg;
  parameter int unsigned OPW = 8;
  parameter int unsigned PRW = 2 * OPW;
  parameter int unsigned ACW = 32;

  typedef logic signed [OPW-1:0] opnd_t;
  typedef logic signed [PRW-1:0] prod_t;
  typedef logic signed [ACW-1:0] acc_t;

  typedef struct packed {
    logic vld;
    logic first;
    logic last;
  } ctl_t;
endpackage

// File: rtl/mac_mul_row.sv
module mac_mul_row
  import mac_grid_pkg::*;
#(
  parameter int unsigned PC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC*OPW-1:0] act_i,
  input  logic [PC*OPW-1:0] wgt_i,
  output logic [PC*ACW-1:0] prod_o
);
  for (genvar c = 0; c < PC; c++) begin : g_mul
    prod_t p;
    acc_t  p_q;
    assign p = opnd_t'(act_i[c*OPW +: OPW]) * opnd_t'(wgt_i[c*OPW +: OPW]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) p_q <= '0;
      else         p_q <= acc_t'(p);
    end
    assign prod_o[c*ACW +: ACW] = p_q;
  end
endmodule

// File: rtl/mac_add_tree.sv
module mac_add_tree #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N*W-1:0] in_i,
  output logic [W-1:0]   sum_o
);
  localparam int unsigned LVL = $clog2(N);

  // one register per level; N must be a power of two
  for (genvar l = 0; l <= LVL; l++) begin : g_lvl
    localparam int unsigned CNT = N >> l;
    logic [CNT*W-1:0] s;
    if (l == 0) begin : g_leaf
      assign s = in_i;
    end else begin : g_node
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s <= '0;
        else begin
          for (int i = 0; i < CNT; i++)
            s[i*W +: W] <= g_lvl[l-1].s[2*i*W +: W] + g_lvl[l-1].s[(2*i+1)*W +: W];
        end
      end
    end
  end

  assign sum_o = g_lvl[LVL].s;
endmodule

// File: rtl/mac_acc_unit.sv
module mac_acc_unit
  import mac_grid_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic first_i,
  input  acc_t add_i,
  output acc_t acc_o
);
  acc_t acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (vld_i) acc_q <= first_i ? add_i : acc_q + add_i;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/mac_grid.sv
module mac_grid
  import mac_grid_pkg::*;
#(
  parameter int unsigned PF = 2,
  parameter int unsigned PV = 2,
  parameter int unsigned PC = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic                 first_i,
  input  logic                 last_i,
  input  logic [PV*PC*OPW-1:0] act_i,
  input  logic [PF*PC*OPW-1:0] wgt_i,
  output logic [PF*PV*ACW-1:0] sum_o,
  output logic                 sum_valid_o
);
  localparam int unsigned LVL   = $clog2(PC);
  localparam int unsigned DEPTH = LVL + 1;

  // control travels beside the product and tree registers
  ctl_t ctl_q [DEPTH];
  ctl_t ctl_acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < DEPTH; j++) ctl_q[j] <= '0;
    end else begin
      ctl_q[0] <= '{vld: in_valid_i, first: in_valid_i & first_i, last: in_valid_i & last_i};
      for (int j = 1; j < DEPTH; j++) ctl_q[j] <= ctl_q[j-1];
    end
  end

  assign ctl_acc = ctl_q[DEPTH-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_valid_o <= 1'b0;
    else         sum_valid_o <= ctl_acc.vld & ctl_acc.last;
  end

  for (genvar f = 0; f < PF; f++) begin : g_flt
    for (genvar v = 0; v < PV; v++) begin : g_pos
      logic [PC*ACW-1:0] prod;
      acc_t              tree_sum;
      acc_t              acc;

      mac_mul_row #(.PC(PC)) u_row (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .act_i  (act_i[v*PC*OPW +: PC*OPW]),
        .wgt_i  (wgt_i[f*PC*OPW +: PC*OPW]),
        .prod_o (prod)
      );

      mac_add_tree #(.N(PC), .W(ACW)) u_tree (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .in_i   (prod),
        .sum_o  (tree_sum)
      );

      mac_acc_unit u_acc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .vld_i   (ctl_acc.vld),
        .first_i (ctl_acc.first),
        .add_i   (tree_sum),
        .acc_o   (acc)
      );

      assign sum_o[(f*PV+v)*ACW +: ACW] = acc;
    end
  end
endmodule

// File: rtl/mac_grid_chk.sv
module mac_grid_chk #(
  parameter int unsigned PC = 4,
  parameter int unsigned SW = 128
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          last_i,
  input logic [SW-1:0] sum_o,
  input logic          sum_valid_o
);
  localparam int unsigned LAT = $clog2(PC) + 2;

  logic [LAT-1:0] vld_q, lst_q;
  logic           seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      lst_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      vld_q  <= {vld_q[LAT-2:0], in_valid_i};
      lst_q  <= {lst_q[LAT-2:0], in_valid_i & last_i};
      if (vld_q[LAT-2]) seen_q <= 1'b1;
    end
  end

  p_reset_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (sum_o == '0 && !sum_valid_o));

  p_valid_timing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_valid_o == lst_q[LAT-1]);

  p_valid_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_valid_o && !lst_q[LAT-2]) |=> !sum_valid_o);

  p_hold_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_q[LAT-2] |=> $stable(sum_o));
endmodule

bind mac_grid mac_grid_chk #(.PC(PC), .SW(PF*PV*mac_grid_pkg::ACW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .last_i      (last_i),
  .sum_o       (sum_o),
  .sum_valid_o (sum_valid_o)
);

// File: tb/mac_grid_bench.sv
module mac_grid_bench;
  localparam int PF  = 2;
  localparam int PV  = 2;
  localparam int PC  = 4;
  localparam int LAT = 4;  // $clog2(PC)+2

  typedef struct packed {
    logic signed [7:0]  a;
    logic signed [7:0]  w;
    logic signed [31:0] e;  // every lane: PC*a*w
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{a: 8'sh01, w: 8'sh01, e: 32'sd4},
    '{a: 8'sh03, w: 8'shfe, e: -32'sd24},
    '{a: 8'sh80, w: 8'sh80, e: 32'sd65536},
    '{a: 8'sh7f, w: 8'sh80, e: -32'sd65024},
    '{a: 8'sh00, w: 8'sh4d, e: 32'sd0},
    '{a: 8'shff, w: 8'shff, e: 32'sd4},
    '{a: 8'sh05, w: 8'sh07, e: 32'sd140}
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0, first = 1'b0, last = 1'b0;
  logic [PV*PC*8-1:0] act = '0;
  logic [PF*PC*8-1:0] wgt = '0;
  logic [PF*PV*32-1:0] sum;
  logic               sum_valid;

  int tests = 0, fails = 0;
  int unsigned seed = 32'h1234_5678;
  int am [PV][PC];
  int wm [PF][PC];
  int run [PF][PV];
  int snap [PF][PV];
  bit done = 1'b0;

  always #4 clk = ~clk;

  mac_grid #(.PF(PF), .PV(PV), .PC(PC)) u_mac_grid (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .first_i(first), .last_i(last),
    .act_i(act), .wgt_i(wgt), .sum_o(sum), .sum_valid_o(sum_valid)
  );

  function automatic int rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[23:16]));
  endfunction

  task automatic fill_uni(input int a, input int w);
    foreach (am[v, c]) am[v][c] = a;
    foreach (wm[f, c]) wm[f][c] = w;
  endtask

  task automatic fill_rnd();
    foreach (am[v, c]) am[v][c] = rnd8();
    foreach (wm[f, c]) wm[f][c] = rnd8();
  endtask

  // drive one accepted tile and update the reference totals
  task automatic send(input bit fi, input bit la);
    @(negedge clk);
    foreach (am[v, c]) act[(v*PC+c)*8 +: 8] = am[v][c][7:0];
    foreach (wm[f, c]) wgt[(f*PC+c)*8 +: 8] = wm[f][c][7:0];
    in_valid = 1'b1; first = fi; last = la;
    for (int f = 0; f < PF; f++)
      for (int v = 0; v < PV; v++) begin
        int d = 0;
        for (int c = 0; c < PC; c++) d += am[v][c] * wm[f][c];
        run[f][v] = fi ? d : run[f][v] + d;
      end
  endtask

  // idle cycle with garbage data and flags
  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; first = 1'b1; last = 1'b1;
    act = {PV*PC/4{$urandom()}};
    wgt = {PF*PC/4{$urandom()}};
  endtask

  task automatic chk_sum(input string req, input bit use_snap);
    bit bad = 1'b0;
    tests++;
    for (int f = 0; f < PF; f++)
      for (int v = 0; v < PV; v++) begin
        int e = use_snap ? snap[f][v] : run[f][v];
        int g = int'($signed(sum[(f*PV+v)*32 +: 32]));
        if (g != e) begin
          $display("FAIL %s lane f%0d v%0d: got %0d expected %0d", req, f, v, g, e);
          bad = 1'b1;
        end
      end
    if (bad) fails++;
  endtask

  task automatic chk_vld(input string req, input bit e);
    tests++;
    if (sum_valid !== e) begin
      $display("FAIL %s valid: got %0b expected %0b", req, sum_valid, e);
      fails++;
    end
  endtask

  task automatic wait_res(input int n);
    repeat (n) idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    foreach (run[f, v]) run[f][v] = 0;
    repeat (3) @(negedge clk);
    chk_sum("R1 in reset", 1'b0);
    chk_vld("R1 in reset", 1'b0);
    rst_n = 1'b1;
    repeat (3) idle();
    chk_sum("R1 after release", 1'b0);
    chk_vld("R1 after release", 1'b0);

    // R2 R3: uniform single-tile table
    for (int i = 0; i < NV; i++) begin
      fill_uni(int'(TBL[i].a), int'(TBL[i].w));
      send(1'b1, 1'b1);
      wait_res(LAT);
      foreach (snap[f, v]) snap[f][v] = int'(TBL[i].e);
      chk_vld("R5 table", 1'b1);
      chk_sum("R3 table", 1'b1);
      idle();
      chk_vld("R5 pulse width", 1'b0);
    end

    // R2: distinct values in every lane
    for (int k = 0; k < 4; k++) begin
      fill_rnd();
      send(1'b1, 1'b1);
      wait_res(LAT);
      chk_vld("R2 random", 1'b1);
      chk_sum("R2 random", 1'b0);
    end

    // R6: idle garbage leaves totals alone
    wait_res(6);
    chk_sum("R6 idle hold", 1'b0);
    chk_vld("R6 idle hold", 1'b0);

    // R4 R7: back-to-back multi-tile job
    fill_rnd(); send(1'b1, 1'b0);
    for (int k = 0; k < 4; k++) begin fill_rnd(); send(1'b0, 1'b0); end
    fill_rnd(); send(1'b0, 1'b1);
    wait_res(LAT);
    chk_vld("R7 stream", 1'b1);
    chk_sum("R4 stream total", 1'b0);

    // R6: gaps inside a job
    fill_rnd(); send(1'b1, 1'b0);
    idle(); idle();
    fill_rnd(); send(1'b0, 1'b0);
    idle();
    fill_rnd(); send(1'b0, 1'b1);
    wait_res(LAT - 1);
    chk_vld("R5 early", 1'b0);
    idle();
    chk_vld("R6 gaps", 1'b1);
    chk_sum("R6 gaps", 1'b0);

    // R7: two single-tile jobs on consecutive cycles
    fill_rnd(); send(1'b1, 1'b1);
    foreach (snap[f, v]) snap[f][v] = run[f][v];
    fill_rnd(); send(1'b1, 1'b1);
    wait_res(LAT - 1);
    chk_vld("R7 job A", 1'b1);
    chk_sum("R7 job A", 1'b1);
    idle();
    chk_vld("R7 job B", 1'b1);
    chk_sum("R4 job B restarts", 1'b0);

    // R3: long job beyond 16 bits, positive then negative
    fill_uni(-128, -128);
    send(1'b1, 1'b0);
    for (int k = 0; k < 38; k++) send(1'b0, 1'b0);
    send(1'b0, 1'b1);
    wait_res(LAT);
    chk_vld("R3 wide positive", 1'b1);
    chk_sum("R3 wide positive", 1'b0);
    fill_uni(127, -128);
    send(1'b1, 1'b0);
    for (int k = 0; k < 38; k++) send(1'b0, 1'b0);
    send(1'b0, 1'b1);
    wait_res(LAT);
    chk_sum("R3 wide negative", 1'b0);

    wait_res(2);
    finish_run();
  end
endmodule